// File: doc/BRIEF.md
# Conveyor Plant Mode Controller

This block controls the operating mode of a bottle-filling conveyor. It turns the plant on and off from two push-buttons, lets the operator pick manual or automatic mode with a selector switch and a confirm button, and drives the conveyor forward or backward from two jog buttons while manual mode is in force. Automatic conveyor sequencing, bottle sensing and filling belong to other logic and are not handled here.

The controller works on a fixed scan. An internal divider raises a scan tick every `SCAN_DIV` clocks. On that tick the button levels, after a synchroniser, are frozen into an input image. On the following clock the controller works out the new state from the frozen image and loads an output image, which drives the pins until the next scan. Every decision within a scan therefore sees one consistent set of input values.

The stop button is wired fail-safe: its input reads 1 while the button is at rest and 0 when it is pressed or its wire breaks. Either case stops the plant.

Top module: `conv_mode_ctrl`

## Requirements
- R1: A 1 on `start_i` for one scan, with `stop_ni` at 1, turns the plant on. The plant stays on after `start_i` returns to 0.
- R2: A 0 on `stop_ni` turns the plant off. When `start_i` is also 1 in the same scan, stop wins and the plant stays off.
- R3: `plant_on_o` is 1 exactly while the plant is on, and is 0 after reset.
- R4: A mode is adopted only on a scan where `adopt_i` is 1 and was 0 in the previous scan's image, and only while the plant is on. A `auto_sel_i` value of 0 adopts manual mode and 1 adopts automatic mode. An adopt press while the plant is off has no effect.
- R5: `man_lamp_o` is 1 only while manual mode is adopted and `auto_lamp_o` is 1 only while automatic mode is adopted. The two lamps are never both 1, and both are 0 when no mode is adopted.
- R6: Turning the plant off clears the adopted mode, and the plant comes back on with no mode adopted.
- R7: When `auto_sel_i` moves away from the adopted mode, the mode is cleared until a new adopt press.
- R8: `fwd_o` follows `jog_fwd_i` and `bwd_o` follows `jog_bwd_i` only while manual mode is adopted. In automatic mode, or with no mode, both drives stay 0.
- R9: When both jog buttons are pressed, neither drive is on. `fwd_o` and `bwd_o` are never 1 together.
- R10: Holding `adopt_i` adopts a mode only once. If the selector then moves while the button is still held, the mode is cleared and is not adopted again.
- R11: The outputs change only on the clock edge that follows a scan tick. With reset released, that is edge `SCAN_DIV+1` and every `SCAN_DIV` edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start button, normally open, 1 when pressed |
| stop_ni | input | 1 | Stop button, normally closed, 0 when pressed or when the wire is broken |
| auto_sel_i | input | 1 | Mode selector: 0 for manual, 1 for automatic |
| adopt_i | input | 1 | Button that confirms the selected mode, 1 when pressed |
| jog_fwd_i | input | 1 | Jog forward button, 1 when pressed |
| jog_bwd_i | input | 1 | Jog backward button, 1 when pressed |
| plant_on_o | output | 1 | Plant-on lamp |
| man_lamp_o | output | 1 | Manual-mode lamp |
| auto_lamp_o | output | 1 | Automatic-mode lamp |
| fwd_o | output | 1 | Conveyor forward drive |
| bwd_o | output | 1 | Conveyor backward drive |

## Verification
The assertions check the invariants on every cycle:
- stop overrides start;
- start latches the plant;
- no mode is held while the plant is off;
- the lamps and the drives are mutually exclusive;
- no drive is on in automatic mode;
- the input image and the output image hold still between scans.

Only the bench scenarios can show the ordered behaviours:
- a held adopt button takes effect once;
- a selector move clears the mode even while the button is still held;
- an adopt press with the plant off is ignored;
- output changes fall on the scan grid counted from reset.

// File: rtl/conv_mode_pkg.sv
package conv_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_MAN  = 2'd1,
    MODE_AUTO = 2'd2
  } mode_e;

  typedef struct packed {
    logic start;
    logic stop_n;
    logic auto_sel;
    logic adopt;
    logic jog_fwd;
    logic jog_bwd;
  } in_img_t;

  localparam int unsigned IN_W = $bits(in_img_t);

  typedef struct packed {
    logic plant;
    logic man;
    logic auto_l;
    logic fwd;
    logic bwd;
  } out_img_t;

endpackage

// File: rtl/conv_scan_tick.sv
module conv_scan_tick #(
  parameter int unsigned SCAN_DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic eval_o
);
  localparam int unsigned CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCAN_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      eval_o <= 1'b0;
    end else begin
      cnt_q  <= tick_o ? '0 : cnt_q + 1'b1;
      eval_o <= tick_o;
    end
  end

  // eval is a single-cycle pulse trailing the tick
  assert_eval_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_o |=> !eval_o);

endmodule

// File: rtl/conv_in_image.sv
module conv_in_image
  import conv_mode_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  in_img_t raw_i,
  output in_img_t img_o
);
  in_img_t synced;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = raw_i;
    end else begin : g_sync
      logic [IN_W-1:0] chain_q [SYNC_STAGES];
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '0;
          else if (s == 0) chain_q[s] <= raw_i;
          else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
        end
      end
      assign synced = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) img_o <= '0;
    else if (tick_i) img_o <= synced;
  end

  assert_img_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(img_o));

endmodule

// File: rtl/conv_mode_core.sv
module conv_mode_core
  import conv_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     eval_i,
  input  in_img_t  img_i,
  output out_img_t nxt_o
);
  logic  plant_q, plant_nx;
  logic  adopt_prev_q, adopt_edge;
  mode_e mode_q, mode_nx, sel_mode;

  assign plant_nx   = img_i.stop_n & (img_i.start | plant_q);
  assign adopt_edge = img_i.adopt & ~adopt_prev_q;
  assign sel_mode   = img_i.auto_sel ? MODE_AUTO : MODE_MAN;

  always_comb begin
    mode_nx = mode_q;
    if (!plant_nx)                                   mode_nx = MODE_NONE;
    else if (adopt_edge)                             mode_nx = sel_mode;
    else if (mode_q != MODE_NONE && sel_mode != mode_q) mode_nx = MODE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plant_q      <= 1'b0;
      mode_q       <= MODE_NONE;
      adopt_prev_q <= 1'b0;
    end else if (eval_i) begin
      plant_q      <= plant_nx;
      mode_q       <= mode_nx;
      adopt_prev_q <= img_i.adopt;
    end
  end

  always_comb begin
    nxt_o        = '0;
    nxt_o.plant  = plant_nx;
    nxt_o.man    = (mode_nx == MODE_MAN);
    nxt_o.auto_l = (mode_nx == MODE_AUTO);
    nxt_o.fwd    = (mode_nx == MODE_MAN) & img_i.jog_fwd & ~img_i.jog_bwd;
    nxt_o.bwd    = (mode_nx == MODE_MAN) & img_i.jog_bwd & ~img_i.jog_fwd;
  end

  assert_stop_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !img_i.stop_n) |=> !plant_q);

  assert_start_latch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && img_i.start && img_i.stop_n) |=> plant_q);

  assert_off_no_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !plant_q |-> (mode_q == MODE_NONE));

  assert_no_adopt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && mode_q == MODE_NONE && adopt_prev_q) |=> (mode_q == MODE_NONE));

endmodule

// File: rtl/conv_out_image.sv
module conv_out_image
  import conv_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     eval_i,
  input  out_img_t nxt_i,
  output out_img_t img_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) img_o <= '0;
    else if (eval_i) img_o <= nxt_i;
  end

  assert_drive_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(img_o.fwd && img_o.bwd));

  assert_lamp_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(img_o.man && img_o.auto_l));

  assert_auto_no_jog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !img_o.man |-> !(img_o.fwd || img_o.bwd));

  assert_lamp_needs_plant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_o.man || img_o.auto_l) |-> img_o.plant);

  assert_out_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(img_o));

endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
  import conv_mode_pkg::*;
#(
  parameter int unsigned SCAN_DIV    = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_ni,
  input  logic auto_sel_i,
  input  logic adopt_i,
  input  logic jog_fwd_i,
  input  logic jog_bwd_i,
  output logic plant_on_o,
  output logic man_lamp_o,
  output logic auto_lamp_o,
  output logic fwd_o,
  output logic bwd_o
);
  logic     tick, eval;
  in_img_t  raw, img;
  out_img_t nxt, oimg;

  assign raw = '{start: start_i, stop_n: stop_ni, auto_sel: auto_sel_i,
                 adopt: adopt_i, jog_fwd: jog_fwd_i, jog_bwd: jog_bwd_i};

  conv_scan_tick #(.SCAN_DIV(SCAN_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick), .eval_o(eval)
  );

  conv_in_image #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk_i, .rst_ni, .tick_i(tick), .raw_i(raw), .img_o(img)
  );

  conv_mode_core u_core (
    .clk_i, .rst_ni, .eval_i(eval), .img_i(img), .nxt_o(nxt)
  );

  conv_out_image u_out (
    .clk_i, .rst_ni, .eval_i(eval), .nxt_i(nxt), .img_o(oimg)
  );

  assign plant_on_o  = oimg.plant;
  assign man_lamp_o  = oimg.man;
  assign auto_lamp_o = oimg.auto_l;
  assign fwd_o       = oimg.fwd;
  assign bwd_o       = oimg.bwd;

endmodule

// File: tb/conv_mode_ctrl_tb.sv
`timescale 1ns/1ps
module conv_mode_ctrl_tb;
  localparam int unsigned DIV = 4;
  localparam int unsigned SETTLE = 2 * DIV + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop_n = 1, sel = 0, adopt = 0, jf = 0, jb = 0;
  logic plant, man, autol, fwd, bwd;

  int checks = 0, fails = 0, cyc = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] prev_out;
  bit         done = 0;

  always #4 clk = ~clk;  // 125 MHz

  conv_mode_ctrl #(.SCAN_DIV(DIV), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_ni(stop_n),
    .auto_sel_i(sel), .adopt_i(adopt), .jog_fwd_i(jf), .jog_bwd_i(jb),
    .plant_on_o(plant), .man_lamp_o(man), .auto_lamp_o(autol),
    .fwd_o(fwd), .bwd_o(bwd)
  );

  wire [4:0] outs = {plant, man, autol, fwd, bwd};

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: scoreboard compare and scan-grid check (R11)
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (outs !== e) begin
        fails++;
        $display("FAIL %s: outputs {plant,man,auto,fwd,bwd} actual %b expected %b", t, outs, e);
      end
    end
    if (rst_n && cyc > 0 && outs !== prev_out) begin
      checks++;
      if (cyc < DIV + 1 || ((cyc - (DIV + 1)) % DIV) != 0) begin
        fails++;
        $display("FAIL R11: output change at edge actual %0d expected on grid %0d+k*%0d",
                 cyc, DIV + 1, DIV);
      end
    end
    prev_out = outs;
  end

  task automatic step(input logic s, sn, se, ad, f, b, input logic [4:0] e, input string t);
    @(negedge clk);
    start = s; stop_n = sn; sel = se; adopt = ad; jf = f; jb = b;
    repeat (SETTLE) @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.push_back(5'b00000); tag_q.push_back("R3 reset state");
    @(negedge clk); @(negedge clk);
    //   start stop_n sel adopt jf jb   expected        tag
    step(1, 1, 0, 0, 0, 0, 5'b10000, "R1 start turns plant on");
    step(0, 1, 0, 0, 0, 0, 5'b10000, "R1 plant latched after release");
    step(0, 1, 0, 0, 1, 0, 5'b10000, "R8 jog with no mode");
    step(0, 1, 0, 1, 0, 0, 5'b11000, "R4 adopt manual");
    step(0, 1, 0, 0, 0, 0, 5'b11000, "R5 manual lamp held");
    step(0, 1, 0, 0, 1, 0, 5'b11010, "R8 jog forward manual");
    step(0, 1, 0, 0, 0, 1, 5'b11001, "R8 jog backward manual");
    step(0, 1, 0, 0, 1, 1, 5'b11000, "R9 both jog buttons");
    step(0, 1, 1, 0, 0, 0, 5'b10000, "R7 selector move clears mode");
    step(0, 1, 1, 1, 0, 0, 5'b10100, "R4 adopt automatic");
    step(0, 1, 1, 1, 1, 0, 5'b10100, "R8 jog ignored in automatic");
    step(0, 1, 0, 0, 0, 0, 5'b10000, "R7 clear from automatic");
    step(0, 1, 0, 1, 0, 0, 5'b11000, "R10 held adopt first take");
    step(0, 1, 1, 1, 0, 0, 5'b10000, "R10 held adopt no re-adopt");
    step(0, 1, 1, 0, 0, 0, 5'b10000, "R10 release adopt");
    step(0, 1, 1, 1, 0, 0, 5'b10100, "R5 automatic lamp");
    step(1, 0, 1, 0, 0, 0, 5'b00000, "R2 stop wins over start");
    step(0, 1, 1, 0, 0, 0, 5'b00000, "R6 mode cleared by stop");
    step(0, 1, 0, 1, 0, 0, 5'b00000, "R4 adopt ignored while off");
    step(1, 1, 0, 1, 0, 0, 5'b10000, "R6 restart with no mode");
    step(0, 0, 0, 0, 0, 0, 5'b00000, "R2 stop input low");
    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule